// File: doc/BRIEF.md
# ARINC 429 Word Receiver with Label Filter

This block takes an ARINC 429 line that has already been turned into two logic levels, one flagging a high (ONE) and one flagging a low (ZERO), with NULL meaning neither or both are active. It oversamples the line and recovers the return-to-zero bits. It frames each 32-bit word on the NULL gap that follows it, and it can drop words whose odd parity is wrong. A word that survives can also be checked against a 16-entry table of accepted labels.

Accepted words are queued in a 32-word FIFO. A host reads each word as two 16-bit halves and then pops it. Three status outputs show the queue level. The host fills the label table through the same 16-bit write bus. While the table is being filled, reception stops.

Configuration inputs select the line rate, the parity check, the label filter and the bit layout presented on the read bus.

Top module: `a429_label_rx`

## Requirements
- R1: The line is sampled once every DIV_HI clocks at high speed (`cfg_hi_speed`=1) or once every DIV_LO clocks at low speed, with 10 samples per bit. A bit is recognised when ONE or ZERO is seen in 3 consecutive samples. A level lasting only 2 samples is not a bit.
- R2: A word ends when 30 consecutive NULL samples are seen. It is kept only if exactly 32 bits arrived since the previous gap. Words with 31 or 33 bits are discarded.
- R3: With `cfg_par_en`=1, a word is kept only if its 32 bits contain an odd number of ones. With `cfg_par_en`=0, bit 32 is plain data and parity is not checked.
- R4: With `cfg_label_en`=1, a word is kept only if its label equals one of the 16 table entries. With `cfg_label_en`=0, every word that passes R2 and R3 is kept. Table entries are 0 after reset.
- R5: A one-cycle `lbl_start` pulse begins a table load. The next 16 `lbl_wr` strobes write `host_wdata[7:0]` into entries 0 to 15 in order, and the 16th write ends the load.
- R6: From `lbl_start` until the load ends, no word is accepted and any partly received word is discarded. Reception resumes after the line has then been NULL for at least 30 samples.
- R7: Accepted words are stored in a 32-entry FIFO and read in arrival order. `data_ready` is 1 while the FIFO holds at least one word.
- R8: `half_full` is 1 while the FIFO holds 16 or more words. `full` is 1 while it holds 32.
- R9: A word accepted while the FIFO is full is dropped, and the 32 stored words are left unchanged.
- R10: `rd_data` shows bits 15:0 of the head word when `half_sel`=0 and bits 31:16 when `half_sel`=1. A one-cycle `rd_pop` removes the head word. `rd_pop` on an empty FIFO has no effect.
- R11: Raw layout (`cfg_unscramble`=0): the bit received i-th (from 0) appears at bit i, so bits 7:0 hold the label MSB first, at bit 0. Unscrambled layout (`cfg_unscramble`=1): bits 7:0 hold the label value with its MSB at bit 7, and bits 31:8 are unchanged.
- R12: A word stored and a `rd_pop` on a non-empty, non-full FIFO in the same cycle both take effect: the head is removed and the new word is queued.
- R13: After reset, `data_ready`, `half_full` and `full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_one | input | 1 | Line is at the ONE level |
| line_zero | input | 1 | Line is at the ZERO level |
| cfg_hi_speed | input | 1 | 1 = high-speed rate, 0 = low-speed rate |
| cfg_par_en | input | 1 | 1 = odd parity checked over all 32 bits |
| cfg_unscramble | input | 1 | 1 = unscrambled read layout |
| cfg_label_en | input | 1 | 1 = label filter active |
| lbl_start | input | 1 | Pulse that starts a label table load |
| lbl_wr | input | 1 | Host write strobe for a table entry |
| host_wdata | input | 16 | Host write bus; bits 7:0 carry the label |
| half_sel | input | 1 | 0 = low half, 1 = high half on rd_data |
| rd_pop | input | 1 | Pulse that removes the head word |
| rd_data | output | 16 | Selected half of the head word |
| data_ready | output | 1 | FIFO not empty |
| half_full | output | 1 | FIFO holds 16 or more words |
| full | output | 1 | FIFO holds 32 words |

## Verification
The FIFO can store a newly framed word and remove the head word for the host in the same cycle. To make this happen on purpose, the bench first times a reference word, at the high rate with one sample per clock, from the end of its last bit to the rise of `data_ready`. For the second word, it lines up a `rd_pop` with the edge that stores that word, while one older word is still queued. The result is correct when, after that edge, `data_ready` stays 1, the head shows the new word, and one more pop empties the FIFO.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2
  } sym_e;

  // Label as a number: the serial order sends the label MSB first into bit 0.
  function automatic logic [7:0] label_of(input logic [31:0] raw);
    logic [7:0] l;
    for (int i = 0; i < 8; i++) l[i] = raw[7-i];
    return l;
  endfunction

  function automatic logic odd_ok(input logic [31:0] w);
    return ^w;
  endfunction

  function automatic logic [31:0] present(input logic [31:0] raw, input logic unscr);
    return unscr ? {raw[31:8], label_of(raw)} : raw;
  endfunction

endpackage

// File: rtl/a429_bit_deframer.sv
module a429_bit_deframer
  import a429_rx_pkg::*;
#(
  parameter int DIV_HI      = 1,
  parameter int DIV_LO      = 8,
  parameter int SMP_PER_BIT = 10,
  parameter int CONFIRM     = 3,
  parameter int GAP_BITS    = 3,
  parameter int WORD_BITS   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_one,
  input  logic                 line_zero,
  input  logic                 hi_speed,
  input  logic                 par_en,
  input  logic                 hold,
  output logic                 word_vld,
  output logic                 word_chk,
  output logic [WORD_BITS-1:0] word_raw
);
  localparam int GAP_SMP = GAP_BITS * SMP_PER_BIT;
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int DW      = $clog2(DIV_MAX + 1);
  localparam int RW      = $clog2(GAP_SMP + 2);
  localparam int BW      = $clog2(WORD_BITS + 2);
  localparam int IW      = $clog2(WORD_BITS);

  logic [DW-1:0]        div_cnt;
  logic                 strobe;
  sym_e                 sym, prev_sym;
  logic [RW-1:0]        run_len, run_next;
  logic [BW-1:0]        bit_cnt;
  logic [WORD_BITS-1:0] sr;
  logic                 synced;
  logic                 bit_evt, gap_evt, idle_ok;

  assign strobe = (div_cnt == '0);

  always_comb begin
    if (line_one && !line_zero)      sym = SYM_ONE;
    else if (line_zero && !line_one) sym = SYM_ZERO;
    else                             sym = SYM_NULL;
  end

  always_comb begin
    if (sym != prev_sym)                    run_next = RW'(1);
    else if (run_len == RW'(GAP_SMP + 1))   run_next = run_len;
    else                                    run_next = run_len + RW'(1);
  end

  assign bit_evt = strobe && (sym != SYM_NULL) && (run_next == RW'(CONFIRM));
  assign gap_evt = strobe && (sym == SYM_NULL) && (run_next == RW'(GAP_SMP));
  assign idle_ok = strobe && (sym == SYM_NULL) && (run_next >= RW'(GAP_SMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      prev_sym <= SYM_NULL;
      run_len  <= '0;
      bit_cnt  <= '0;
      sr       <= '0;
      synced   <= 1'b0;
      word_vld <= 1'b0;
      word_chk <= 1'b0;
      word_raw <= '0;
    end else begin
      if (strobe) div_cnt <= hi_speed ? DW'(DIV_HI - 1) : DW'(DIV_LO - 1);
      else        div_cnt <= div_cnt - DW'(1);
      if (strobe) begin
        prev_sym <= sym;
        run_len  <= run_next;
      end
      word_vld <= 1'b0;
      if (hold) begin
        synced  <= 1'b0;
        bit_cnt <= '0;
      end else begin
        if (gap_evt) begin
          word_vld <= synced && (bit_cnt == BW'(WORD_BITS)) && (!par_en || odd_ok(sr));
          word_chk <= par_en;
          word_raw <= sr;
          bit_cnt  <= '0;
        end
        if (idle_ok) synced <= 1'b1;
        if (bit_evt && synced) begin
          if (bit_cnt < BW'(WORD_BITS))  sr[bit_cnt[IW-1:0]] <= (sym == SYM_ONE);
          if (bit_cnt <= BW'(WORD_BITS)) bit_cnt <= bit_cnt + BW'(1);
        end
      end
    end
  end

  AST_HOLD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (bit_cnt == '0) && !word_vld); // R6
  AST_WORD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R2
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt && synced && !hold |=> bit_cnt != '0); // R1

endmodule

// File: rtl/a429_label_table.sv
module a429_label_table #(
  parameter int N_LABELS = 16,
  parameter int LW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [LW-1:0] wdata,
  input  logic [LW-1:0] label,
  output logic          busy,
  output logic          hit
);
  localparam int XW = $clog2(N_LABELS);

  logic [LW-1:0]       tbl [N_LABELS];
  logic [XW-1:0]       idx;
  logic [N_LABELS-1:0] match;

  for (genvar g = 0; g < N_LABELS; g++) begin : g_cmp
    assign match[g] = (tbl[g] == label);
  end
  assign hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      for (int i = 0; i < N_LABELS; i++) tbl[i] <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && wr) begin
      tbl[idx] <= wdata;
      if (idx == XW'(N_LABELS - 1)) busy <= 1'b0;
      else                          idx  <= idx + XW'(1);
    end
  end

  AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr && !start && (idx == XW'(N_LABELS - 1)) |=> !busy); // R5
  AST_LOAD_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (idx == '0)); // R5

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         half,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign half    = (count >= CW'(DEPTH / 2));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full && $stable(wptr)); // R9
  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !full && !empty |=> $stable(count)); // R12
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty && $stable(rptr)); // R10

endmodule

// File: rtl/a429_label_rx.sv
module a429_label_rx
  import a429_rx_pkg::*;
#(
  parameter int DIV_HI     = 1,
  parameter int DIV_LO     = 8,
  parameter int N_LABELS   = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_one,
  input  logic        line_zero,
  input  logic        cfg_hi_speed,
  input  logic        cfg_par_en,
  input  logic        cfg_unscramble,
  input  logic        cfg_label_en,
  input  logic        lbl_start,
  input  logic        lbl_wr,
  input  logic [15:0] host_wdata,
  input  logic        half_sel,
  input  logic        rd_pop,
  output logic [15:0] rd_data,
  output logic        data_ready,
  output logic        half_full,
  output logic        full
);
  localparam int WORD_BITS = 32;

  logic                 word_vld, word_chk;
  logic [WORD_BITS-1:0] word_raw, head_raw, head_view;
  logic                 lbl_busy, lbl_hit, rx_hold;
  logic                 fifo_push, fifo_empty;

  assign rx_hold = lbl_busy || lbl_start;

  a429_bit_deframer #(
    .DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .SMP_PER_BIT(10),
    .CONFIRM(3), .GAP_BITS(3), .WORD_BITS(WORD_BITS)
  ) u_deframer (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .hi_speed(cfg_hi_speed), .par_en(cfg_par_en), .hold(rx_hold),
    .word_vld(word_vld), .word_chk(word_chk), .word_raw(word_raw)
  );

  a429_label_table #(.N_LABELS(N_LABELS), .LW(8)) u_labels (
    .clk(clk), .rst_n(rst_n), .start(lbl_start), .wr(lbl_wr),
    .wdata(host_wdata[7:0]), .label(label_of(word_raw)),
    .busy(lbl_busy), .hit(lbl_hit)
  );

  assign fifo_push = word_vld && !rx_hold && (!cfg_label_en || lbl_hit);

  a429_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(word_raw),
    .pop(rd_pop), .rdata(head_raw), .empty(fifo_empty),
    .half(half_full), .full(full)
  );

  assign data_ready = !fifo_empty;
  assign head_view  = present(head_raw, cfg_unscramble);
  assign rd_data    = half_sel ? head_view[31:16] : head_view[15:0];

  AST_PARITY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push && word_chk |-> odd_ok(word_raw)); // R3
  AST_NO_STORE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_busy && fifo_empty && !rd_pop |=> fifo_empty); // R6
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |-> !data_ready && !half_full && !full); // R13

endmodule

// File: tb/a429_label_rx_tb.sv
module a429_label_rx_tb;
  localparam int DIV_HI = 1;
  localparam int DIV_LO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_one = 1'b0, line_zero = 1'b0;
  logic        cfg_hi_speed = 1'b1, cfg_par_en = 1'b1;
  logic        cfg_unscramble = 1'b0, cfg_label_en = 1'b0;
  logic        lbl_start = 1'b0, lbl_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        half_sel = 1'b0, rd_pop = 1'b0;
  logic [15:0] rd_data;
  logic        data_ready, half_full, full;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [31:0] q_raw[$];
  logic [7:0]  q_lbl[$];

  always #5 clk = ~clk;

  a429_label_rx #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .cfg_hi_speed(cfg_hi_speed), .cfg_par_en(cfg_par_en),
    .cfg_unscramble(cfg_unscramble), .cfg_label_en(cfg_label_en),
    .lbl_start(lbl_start), .lbl_wr(lbl_wr), .host_wdata(host_wdata),
    .half_sel(half_sel), .rd_pop(rd_pop), .rd_data(rd_data),
    .data_ready(data_ready), .half_full(half_full), .full(full)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Word built in serial order: label MSB first, then 23 data bits, then parity.
  function automatic logic [31:0] mk_word(input logic [7:0] lbl, input logic [22:0] dat,
                                          input bit bad_par);
    logic [31:0] w;
    for (int i = 0; i < 8; i++) w[i] = lbl[7-i];
    w[30:8] = dat;
    w[31] = 1'b1;
    if ((($countones(w[30:0]) + 1) % 2) == 0) w[31] = 1'b0;
    if (bad_par) w[31] = ~w[31];
    return w;
  endfunction

  function automatic logic [7:0] tbl_val(input int i);
    return 8'(8'h21 + i * 9);
  endfunction

  task automatic idle(input int samples, input int div);
    @(negedge clk);
    line_one = 1'b0; line_zero = 1'b0;
    repeat (samples * div) @(negedge clk);
  endtask

  // Bits of a word, each 5 samples at level then 5 NULL; short_idx gets 2 samples.
  task automatic send_body(input logic [31:0] raw, input int nbits, input int div,
                           input int short_idx);
    for (int b = 0; b < nbits; b++) begin
      logic v;
      int hi_n;
      v = (b < 32) ? raw[b] : 1'b0;
      hi_n = (b == short_idx) ? 2 : 5;
      line_one = v; line_zero = ~v;
      repeat (hi_n * div) @(negedge clk);
      line_one = 1'b0; line_zero = 1'b0;
      repeat ((10 - hi_n) * div) @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [31:0] raw, input logic [7:0] lbl, input int nbits,
                           input int div, input int short_idx, input bit accept_exp);
    if (accept_exp) begin
      q_raw.push_back(raw);
      q_lbl.push_back(lbl);
    end
    send_body(raw, nbits, div, short_idx);
    repeat (35 * div) @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] w);
    half_sel = 1'b0;
    #1 w[15:0] = rd_data;
    half_sel = 1'b1;
    #1 w[31:16] = rd_data;
    half_sel = 1'b0;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  function automatic logic [31:0] expect_view(input logic [31:0] raw, input logic [7:0] lbl);
    return cfg_unscramble ? {raw[31:8], lbl} : raw;
  endfunction

  task automatic settle(input string req);
    repeat (20) @(negedge clk);
    chk(q_raw.size() == 0, req, "expected words not all delivered", q_raw.size(), 0);
    q_raw.delete();
    q_lbl.delete();
  endtask

  task automatic pulse_start();
    @(negedge clk); lbl_start = 1'b1;
    @(negedge clk); lbl_start = 1'b0;
  endtask

  task automatic write_lbl(input logic [7:0] v);
    @(negedge clk); host_wdata = {8'hA5, v}; lbl_wr = 1'b1;
    @(negedge clk); lbl_wr = 1'b0;
  endtask

  // Monitor: scoreboard pop and compare (R7 order, R10 halves, R11 layout).
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && data_ready) begin
        logic [31:0] got, exp;
        read_word(got);
        if (q_raw.size() == 0) begin
          chk(1'b0, "R7", "unexpected word stored", got, 0);
        end else begin
          exp = expect_view(q_raw.pop_front(), q_lbl.pop_front());
          chk(got == exp, "R7", "word read in order (R10 halves, R11 layout)", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, got;
    int n;
    repeat (3) @(negedge clk);
    chk(!data_ready, "R13", "data_ready after reset", data_ready, 0);
    chk(!half_full, "R13", "half_full after reset", half_full, 0);
    chk(!full, "R13", "full after reset", full, 0);
    rst_n = 1'b1;
    idle(35, DIV_HI);

    // Basic reception with the monitor draining (R7, R10, R11 raw layout).
    mon_en = 1'b1;
    send_word(mk_word(8'h5C, 23'h12345, 0), 8'h5C, 32, DIV_HI, -1, 1);
    send_word(mk_word(8'h03, 23'h7FFFF0, 0), 8'h03, 32, DIV_HI, -1, 1);
    send_word(mk_word(8'hF0, 23'h000001, 0), 8'hF0, 32, DIV_HI, -1, 1);
    settle("R7");

    // R11 unscrambled layout.
    cfg_unscramble = 1'b1;
    send_word(mk_word(8'hB1, 23'h2AAAAA, 0), 8'hB1, 32, DIV_HI, -1, 1);
    settle("R11");
    cfg_unscramble = 1'b0;

    // R3 parity: rejected when enabled, kept as data when disabled.
    send_word(mk_word(8'h44, 23'h0F0F0F, 1), 8'h44, 32, DIV_HI, -1, 0);
    settle("R3");
    cfg_par_en = 1'b0;
    send_word(mk_word(8'h44, 23'h0F0F0F, 1), 8'h44, 32, DIV_HI, -1, 1);
    settle("R3");
    cfg_par_en = 1'b1;

    // R2 word length.
    send_word(mk_word(8'h11, 23'h111, 0), 8'h11, 31, DIV_HI, -1, 0);
    send_word(mk_word(8'h12, 23'h222, 0), 8'h12, 33, DIV_HI, -1, 0);
    settle("R2");
    send_word(mk_word(8'h13, 23'h333, 0), 8'h13, 32, DIV_HI, -1, 1);
    settle("R2");

    // R1: a 2-sample bit is not a bit; low-speed word is received.
    send_word(mk_word(8'h21, 23'h4444, 0), 8'h21, 32, DIV_HI, 10, 0);
    settle("R1");
    cfg_hi_speed = 1'b0;
    idle(35, DIV_LO);
    send_word(mk_word(8'h77, 23'h5A5A5, 0), 8'h77, 32, DIV_LO, -1, 1);
    settle("R1");
    cfg_hi_speed = 1'b1;
    idle(35, DIV_HI);

    // R5 table load, R4 filtering.
    pulse_start();
    for (int i = 0; i < 16; i++) write_lbl(tbl_val(i));
    idle(35, DIV_HI);
    cfg_label_en = 1'b1;
    send_word(mk_word(tbl_val(15), 23'h1, 0), tbl_val(15), 32, DIV_HI, -1, 1);
    send_word(mk_word(tbl_val(0), 23'h2, 0), tbl_val(0), 32, DIV_HI, -1, 1);
    send_word(mk_word(8'h20, 23'h3, 0), 8'h20, 32, DIV_HI, -1, 0);
    settle("R4");
    cfg_label_en = 1'b0;
    send_word(mk_word(8'h20, 23'h3, 0), 8'h20, 32, DIV_HI, -1, 1);
    settle("R4");

    // R6 reception suspended during a load.
    pulse_start();
    for (int i = 0; i < 3; i++) write_lbl(tbl_val(i));
    send_word(mk_word(8'h66, 23'h6, 0), 8'h66, 32, DIV_HI, -1, 0);
    for (int i = 3; i < 16; i++) write_lbl(tbl_val(i));
    settle("R6");
    idle(35, DIV_HI);
    send_word(mk_word(8'h67, 23'h7, 0), 8'h67, 32, DIV_HI, -1, 1);
    settle("R6");

    // R10 pop on empty ignored.
    mon_en = 1'b0;
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
    w = mk_word(8'h3C, 23'h3C3C3, 0);
    send_word(w, 8'h3C, 32, DIV_HI, -1, 0);
    chk(data_ready, "R10", "word present after empty pop", data_ready, 1);
    read_word(got);
    chk(got == w, "R10", "word after empty pop", got, w);
    chk(!data_ready, "R10", "empty after read", data_ready, 0);

    // R12 push and pop in the same cycle.
    w = mk_word(8'h0A, 23'h0A0A, 0);
    send_body(w, 32, DIV_HI, -1);
    n = 0;
    while (!data_ready && n < 200) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    w = mk_word(8'h0B, 23'h0B0B, 0);
    send_body(w, 32, DIV_HI, -1);
    repeat (n - 1) @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(data_ready, "R12", "data_ready after collision", data_ready, 1);
    repeat (40) @(negedge clk);
    read_word(got);
    chk(got == w, "R12", "new word at head after collision", got, w);
    chk(!data_ready, "R12", "one word left after collision", data_ready, 0);

    // R8 flags and R9 overflow drop.
    for (int i = 0; i < 33; i++) begin
      w = mk_word(8'(i), 23'(i * 77), 0);
      send_word(w, 8'(i), 32, DIV_HI, -1, i < 32);
      if (i == 14) chk(!half_full, "R8", "half_full at 15 words", half_full, 0);
      if (i == 15) chk(half_full, "R8", "half_full at 16 words", half_full, 1);
      if (i == 30) chk(!full, "R8", "full at 31 words", full, 0);
      if (i == 31) chk(full, "R8", "full at 32 words", full, 1);
    end
    chk(full, "R9", "still full after dropped word", full, 1);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] e;
      read_word(got);
      e = q_raw.pop_front();
      void'(q_lbl.pop_front());
      chk(got == e, "R9", "stored word unchanged", got, e);
    end
    chk(!data_ready, "R9", "dropped word absent", data_ready, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule